// File: doc/BRIEF.md
# Transition-Count Loss-of-Signal Detector

This block sits on a received serial bit stream, sampled once per bit clock, and flags loss of signal when the line stops toggling. A long run with no data transition raises the flag. The flag is dropped only after the line shows sustained activity. That activity is measured as a transition count over fixed, back-to-back windows, so the flag cannot chatter on an isolated edge.

While the flag is up, the serial data handed downstream is held at logic 0. Downstream logic therefore sees a clean failure indication instead of noise. An active-low enable turns the internal detector off. An active-low external indication, typically from an optical module, forces the flag on whatever the enable is set to.

Top module: `los_detector`

## Requirements
- R1: Transitions are taken against the previously sampled bit (0 after reset). If data_i is sampled with no transition on 129 consecutive clock edges that follow a transitioning bit, los_o rises after the 129th such edge. A transition after 128 such edges leaves los_o low.
- R2: Windows of 128 bits run back to back from reset. At the last bit of a window, the internal flag clears when that window held more than 16 transitions, counting the last bit itself. A window with exactly 16 transitions leaves the flag set.
- R3: data_o equals data_i while los_o is low and is 0 while los_o is high.
- R4: While det_en_ni is high, the internal flag is cleared at the next clock edge and stays clear. A long idle run then does not raise los_o.
- R5: While ext_los_ni is low, los_o is high in the same cycle, whatever det_en_ni is set to.
- R6: After reset, los_o is high and data_o is 0.
- R7: The no-transition run counter saturates, so an idle line of any length keeps los_o high without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial received data, one bit per clock |
| det_en_ni | input | 1 | Internal detection enable, active low |
| ext_los_ni | input | 1 | External loss indication, active low |
| los_o | output | 1 | Loss-of-signal flag |
| data_o | output | 1 | Received data, forced to 0 during loss of signal |

## Verification
A run counter that is off by one moves the rising edge of los_o by one bit. The bench catches this on the exact edge of the 128-idle-bit boundary. A window or transition counter that is wrong shows up as a flag that clears one window early or late, or clears with only 16 transitions. That error becomes visible at the end of the affected 128-bit window. Gating errors appear on data_o in the same cycle, because the reference model is compared on every clock.

// File: rtl/los_pkg.sv
package los_pkg;
  parameter int unsigned LOS_RUN_BITS  = 128;
  parameter int unsigned LOS_WIN_BITS  = 128;
  parameter int unsigned LOS_CLR_EDGES = 16;
endpackage

// File: rtl/los_edge_det.sv
module los_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic edge_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= data_i;
  end

  assign edge_o = data_i ^ d_q;
endmodule

// File: rtl/los_run_cnt.sv
module los_run_cnt #(
  parameter int unsigned RUN_LIMIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic full_o
);
  localparam int unsigned RW = $clog2(RUN_LIMIT + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (edge_i)                  run_q <= '0;
    else if (run_q < RW'(RUN_LIMIT))  run_q <= run_q + RW'(1);
  end

  assign full_o = (run_q >= RW'(RUN_LIMIT));

  AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> run_q == '0); // R1

  AST_RUN_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RUN_LIMIT)); // R7
endmodule

// File: rtl/los_win_cnt.sv
module los_win_cnt #(
  parameter int unsigned WIN_LEN   = 128,
  parameter int unsigned CLR_EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic win_end_o,
  output logic enough_o
);
  localparam int unsigned WW  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned SAT = CLR_EDGES + 1;
  localparam int unsigned TW  = $clog2(SAT + 1);

  logic [WW-1:0] win_q;
  logic [TW-1:0] tcnt_q;

  assign win_end_o = (win_q == WW'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '0;
    else if (win_end_o) win_q <= '0;
    else                win_q <= win_q + WW'(1);
  end

  // count saturates one above the threshold; cleared at window end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               tcnt_q <= '0;
    else if (win_end_o)                        tcnt_q <= '0;
    else if (edge_i && tcnt_q < TW'(SAT))      tcnt_q <= tcnt_q + TW'(1);
  end

  assign enough_o = (tcnt_q == TW'(SAT)) || (edge_i && tcnt_q == TW'(CLR_EDGES));

  AST_TCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q <= TW'(SAT)); // R2

  AST_WIN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> tcnt_q == '0); // R2
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = LOS_RUN_BITS,
  parameter int unsigned WIN_LEN   = LOS_WIN_BITS,
  parameter int unsigned CLR_EDGES = LOS_CLR_EDGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic det_en_ni,
  input  logic ext_los_ni,
  output logic los_o,
  output logic data_o
);
  logic edge_w, full_w, win_end_w, enough_w;
  logic los_q;

  los_edge_det i_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .edge_o (edge_w)
  );

  los_run_cnt #(.RUN_LIMIT(RUN_LIMIT)) i_run (
    .clk_i (clk_i), .rst_ni (rst_ni), .edge_i (edge_w), .full_o (full_w)
  );

  los_win_cnt #(.WIN_LEN(WIN_LEN), .CLR_EDGES(CLR_EDGES)) i_win (
    .clk_i (clk_i), .rst_ni (rst_ni), .edge_i (edge_w),
    .win_end_o (win_end_w), .enough_o (enough_w)
  );

  // clear has priority over set; flag starts asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     los_q <= 1'b1;
    else if (det_en_ni)              los_q <= 1'b0;
    else if (win_end_w && enough_w)  los_q <= 1'b0;
    else if (full_w && !edge_w)      los_q <= 1'b1;
  end

  assign los_o  = los_q | ~ext_los_ni;
  assign data_o = data_i & ~los_o;

  AST_SET_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_ni && full_w && !edge_w) |=> los_q); // R1

  AST_SET_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_q) |-> $past(full_w)); // R7

  AST_CLEAR_AT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(los_q) && !$past(det_en_ni)) |-> $past(win_end_w && enough_w)); // R2

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_en_ni |=> !los_q); // R4
endmodule

// File: tb/test_los_detector.sv
module test_los_detector;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic det_en_ni = 1'b0;
  logic ext_los_ni = 1'b1;
  logic los_o, data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  los_detector i_los_detector (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (data_i), .det_en_ni (det_en_ni),
    .ext_los_ni (ext_los_ni), .los_o (los_o), .data_o (data_o)
  );

  // behavioural reference
  int m_prev, m_run, m_win, m_tc;
  bit m_los;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev = 0; m_run = 0; m_win = 0; m_tc = 0; m_los = 1'b1;
    end else begin
      int t;
      bit last;
      t = (int'(data_i) != m_prev) ? 1 : 0;
      m_prev = int'(data_i);
      last = (m_win == 127);
      if (det_en_ni)                    m_los = 1'b0;
      else if (last && m_tc + t > 16)   m_los = 1'b0;
      else if (m_run >= 128 && t == 0)  m_los = 1'b1;
      m_run = (t != 0) ? 0 : ((m_run < 1000) ? m_run + 1 : m_run);
      m_tc  = last ? 0 : m_tc + t;
      m_win = (m_win + 1) % 128;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit d);
    bit e_los;
    @(negedge clk);
    e_los = m_los | ~ext_los_ni;
    check(los_o == e_los, "R1 R2 R4 R5 flag vs model", los_o, e_los);
    check(data_o == (data_i & ~e_los), "R3 data gating vs model", data_o, data_i & ~e_los);
    data_i = d;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) cyc(data_i);
  endtask

  task automatic toggle_every(input int gap, input int n);
    for (int i = 0; i < n; i++) cyc((i % gap == gap - 1) ? ~data_i : data_i);
  endtask

  task automatic dchk(input bit exp_los, input string req);
    #1;
    check(los_o == exp_los, req, los_o, exp_los);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    data_i = 1'b1;
    #22 rst_ni = 1'b1;
    #1;
    check(los_o == 1'b1, "R6 reset flag", los_o, 1);
    check(data_o == 1'b0, "R6 reset data", data_o, 0);
    // busy line clears the flag
    toggle_every(1, 300);
    dchk(1'b0, "R2 cleared by activity");
    // boundary: 128 idle bits after a transition, then transition
    cyc(~data_i); hold(128); cyc(~data_i);
    dchk(1'b0, "R1 no set at 128 idle");
    hold(5);
    // 129 idle bits raise the flag
    cyc(~data_i); hold(129); hold(2);
    dchk(1'b1, "R1 set after 129 idle");
    hold(1000);
    dchk(1'b1, "R7 long idle stays set");
    // exactly 16 transitions per window do not clear
    toggle_every(8, 384);
    dchk(1'b1, "R2 16 per window holds flag");
    toggle_every(7, 300);
    dchk(1'b0, "R2 17 or more clears");
    // detection disabled
    det_en_ni = 1'b1;
    hold(500);
    dchk(1'b0, "R4 disabled ignores idle");
    det_en_ni = 1'b0;
    hold(200);
    dchk(1'b1, "R4 re-enabled sets again");
    toggle_every(1, 300);
    dchk(1'b0, "R2 cleared again");
    // external force
    ext_los_ni = 1'b0;
    dchk(1'b1, "R5 external forces flag");
    det_en_ni = 1'b1;
    toggle_every(1, 50);
    data_i = 1'b1;
    dchk(1'b1, "R5 external with detection off");
    check(data_o == 1'b0, "R3 data forced low", data_o, 0);
    ext_los_ni = 1'b1;
    hold(3);
    dchk(1'b0, "R5 release external");
    #1;
    check(data_o == data_i, "R3 data passes", data_o, data_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule